// File: doc/BRIEF.md
# SPI Status Flag Unit

This block keeps the status flags of an SPI controller and presents them as one read-only 32-bit status word. The other parts of the controller send it single-cycle event strobes: enable and disable commands, a transmit data write, the move of transmit data into the shifter, the load of the receive register from the shifter, a mode-fault detection and the end of the configured inter-transfer delay. It also receives level inputs for shifter idle, delay configured and the raw slave-select pin. The bus side sends read strobes for the status word and for the receive data register. Some flags are level flags. Some are sticky and clear when the status word or the receive register is read.

Each flag is a register with its own set and clear rule. The status word is assembled from these registers without further logic, so a flag appears on `status_o` in the cycle after the edge that samples its event. The slave-select pin first passes through a synchroniser with a parameterised number of stages, and only then is a rising edge detected. When a set event and a clear happen in the same cycle, the set event wins, so no event is lost while it is being read.

Top module: `spi_stat_unit`

## Requirements
- R1: After reset the whole status word reads 0x00000000. Every bit other than 0, 1, 2, 3, 8, 9 and 16 always reads 0.
- R2: Bit 16 reads 1 from the edge after an enable strobe until the edge after a disable strobe. When both strobes arrive together, the disable strobe wins.
- R3: Bit 1 (transmit register empty) is 0 at reset and while the SPI is disabled. An enable strobe sets it to 1, even when the SPI is already enabled. A transmit data write clears it. A transmit-to-shifter handoff sets it. A handoff in the same cycle as a write wins over the write.
- R4: Bit 9 (all transmit empty) clears on the edge that samples a transmit data write. It sets once bit 1 is 1 and the shifter is idle. When a delay is configured, it also waits for the delay-done strobe.
- R5: Bit 8 sets on a rising edge of the slave-select pin, 3 clock edges after the pin changes (2 synchroniser stages plus 1 edge register). A status read clears it.
- R6: Bit 3 (overrun) sets when the receive register is loaded while bit 0 is already 1 and the receive register is not read in that same cycle. It stays set until a status read.
- R7: Bit 2 (mode fault) latches a mode-fault strobe and clears on a status read.
- R8: Bit 0 (receive full) sets on a receive-register load and clears on a receive-register read.
- R9: When a set event arrives in the same cycle as the read that would clear the flag, the flag ends up 1. This applies to bits 0, 2, 3 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_cmd_i | input | 1 | Enable command strobe |
| dis_cmd_i | input | 1 | Disable command strobe |
| tx_wr_i | input | 1 | Transmit data register written |
| tx_load_i | input | 1 | Transmit data moved into the shifter |
| shift_idle_i | input | 1 | Shifter holds no data (level) |
| dly_on_i | input | 1 | Inter-transfer delay configured (level) |
| dly_done_i | input | 1 | Inter-transfer delay finished strobe |
| rx_load_i | input | 1 | Receive register loaded from the shifter |
| rdr_rd_i | input | 1 | Receive data register read strobe |
| sr_rd_i | input | 1 | Status word read strobe |
| modf_i | input | 1 | Mode-fault detected strobe |
| ss_pin_i | input | 1 | Raw asynchronous slave-select pin |
| status_o | output | 32 | Status word |

## Verification
Directed sequences cover several cases. Two receive loads with no read between them must raise overrun. With a read between them, or a read in the same cycle as the second load, overrun must not rise. Enabling an SPI that is already enabled, after a transmit write, shows whether the enable command forces bit 1 back to 1. Running with and without a configured delay shows whether bit 9 waits for the delay-done strobe. Status reads in the same cycle as mode-fault and slave-select edges show the set-wins rule. A long random phase, with sparse strobes and a slowly toggling slave-select pin, is compared against a behavioural model on every cycle. It finds wrong priorities between strobes that collide.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam int STAT_W       = 32;
    localparam int POS_RX_FULL  = 0;
    localparam int POS_TXREG_E  = 1;
    localparam int POS_MODE_FLT = 2;
    localparam int POS_OVERRUN  = 3;
    localparam int POS_SS_RISE  = 8;
    localparam int POS_TX_ALL_E = 9;
    localparam int POS_ENABLED  = 16;

    typedef struct packed {
        logic enabled;
        logic tx_all_empty;
        logic ss_rise;
        logic overrun;
        logic mode_fault;
        logic txreg_empty;
        logic rx_full;
    } stat_flags_t;

    function automatic logic [STAT_W-1:0] pack_status(stat_flags_t f);
        logic [STAT_W-1:0] w;
        w               = '0;
        w[POS_RX_FULL]  = f.rx_full;
        w[POS_TXREG_E]  = f.txreg_empty;
        w[POS_MODE_FLT] = f.mode_fault;
        w[POS_OVERRUN]  = f.overrun;
        w[POS_SS_RISE]  = f.ss_rise;
        w[POS_TX_ALL_E] = f.tx_all_empty;
        w[POS_ENABLED]  = f.enabled;
        return w;
    endfunction

endpackage

// File: rtl/spi_stat_ss_edge.sv
module spi_stat_ss_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b1;
        else     chain_q[0] <= pin_i;
    end

    for (genvar g = 1; g < CHAIN; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b1;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    initial begin
        assert (STAGES >= 2) else $error("synchroniser needs two or more stages");
    end

    // R5: an edge is reported for one cycle only
    p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/spi_stat_txflags.sv
module spi_stat_txflags (
    input  logic clk,
    input  logic rst,
    input  logic en_cmd_i,
    input  logic dis_cmd_i,
    input  logic tx_wr_i,
    input  logic tx_load_i,
    input  logic shift_idle_i,
    input  logic dly_on_i,
    input  logic dly_done_i,
    output logic enabled_o,
    output logic txreg_empty_o,
    output logic tx_all_empty_o
);
    logic en_q, tdre_q, txe_q;
    logic drain_ok;

    assign drain_ok = tdre_q & shift_idle_i & (~dly_on_i | dly_done_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            tdre_q <= 1'b0;
            txe_q  <= 1'b0;
        end else begin
            if (dis_cmd_i)     en_q <= 1'b0;
            else if (en_cmd_i) en_q <= 1'b1;

            if (dis_cmd_i || (!en_q && !en_cmd_i)) tdre_q <= 1'b0;
            else if (en_cmd_i || tx_load_i)        tdre_q <= 1'b1;
            else if (tx_wr_i)                      tdre_q <= 1'b0;

            if (tx_wr_i)       txe_q <= 1'b0;
            else if (drain_ok) txe_q <= 1'b1;
        end
    end

    assign enabled_o      = en_q;
    assign txreg_empty_o  = tdre_q;
    assign tx_all_empty_o = txe_q;

    p_dis_wins_r2: assert property (@(posedge clk) disable iff (rst)
        dis_cmd_i |=> !enabled_o);
    p_en_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (en_cmd_i && !dis_cmd_i) |=> (txreg_empty_o && enabled_o));
    p_off_empty_r3: assert property (@(posedge clk) disable iff (rst)
        !enabled_o |-> !txreg_empty_o);
    p_wr_clears_r4: assert property (@(posedge clk) disable iff (rst)
        tx_wr_i |=> !tx_all_empty_o);
endmodule

// File: rtl/spi_stat_rxflags.sv
module spi_stat_rxflags (
    input  logic clk,
    input  logic rst,
    input  logic rx_load_i,
    input  logic rdr_rd_i,
    input  logic sr_rd_i,
    input  logic modf_i,
    input  logic ss_rise_i,
    output logic rx_full_o,
    output logic overrun_o,
    output logic mode_fault_o,
    output logic ss_rise_o
);
    logic rdrf_q, ovr_q, modf_q, nssr_q;
    logic ovr_hit;

    assign ovr_hit = rx_load_i & rdrf_q & ~rdr_rd_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdrf_q <= 1'b0;
            ovr_q  <= 1'b0;
            modf_q <= 1'b0;
            nssr_q <= 1'b0;
        end else begin
            if (rx_load_i)     rdrf_q <= 1'b1;
            else if (rdr_rd_i) rdrf_q <= 1'b0;

            if (ovr_hit)       ovr_q <= 1'b1;
            else if (sr_rd_i)  ovr_q <= 1'b0;

            if (modf_i)        modf_q <= 1'b1;
            else if (sr_rd_i)  modf_q <= 1'b0;

            if (ss_rise_i)     nssr_q <= 1'b1;
            else if (sr_rd_i)  nssr_q <= 1'b0;
        end
    end

    assign rx_full_o    = rdrf_q;
    assign overrun_o    = ovr_q;
    assign mode_fault_o = modf_q;
    assign ss_rise_o    = nssr_q;

    p_load_full_r8: assert property (@(posedge clk) disable iff (rst)
        rx_load_i |=> rx_full_o);
    p_double_load_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_load_i && rx_full_o && !rdr_rd_i) |=> overrun_o);
    p_modf_latch_r7: assert property (@(posedge clk) disable iff (rst)
        modf_i |=> mode_fault_o);
    p_edge_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (ss_rise_i && sr_rd_i) |=> ss_rise_o);
    p_sr_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (sr_rd_i && !modf_i) |=> !mode_fault_o);
endmodule

// File: rtl/spi_stat_unit.sv
module spi_stat_unit
    import spi_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_cmd_i,
    input  logic              dis_cmd_i,
    input  logic              tx_wr_i,
    input  logic              tx_load_i,
    input  logic              shift_idle_i,
    input  logic              dly_on_i,
    input  logic              dly_done_i,
    input  logic              rx_load_i,
    input  logic              rdr_rd_i,
    input  logic              sr_rd_i,
    input  logic              modf_i,
    input  logic              ss_pin_i,
    output logic [STAT_W-1:0] status_o
);
    stat_flags_t flags;
    logic        ss_rise_pulse;

    spi_stat_ss_edge #(.STAGES(SYNC_STAGES)) u_ss_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ss_pin_i),
        .rise_o (ss_rise_pulse)
    );

    spi_stat_txflags u_tx (
        .clk            (clk),
        .rst            (rst),
        .en_cmd_i       (en_cmd_i),
        .dis_cmd_i      (dis_cmd_i),
        .tx_wr_i        (tx_wr_i),
        .tx_load_i      (tx_load_i),
        .shift_idle_i   (shift_idle_i),
        .dly_on_i       (dly_on_i),
        .dly_done_i     (dly_done_i),
        .enabled_o      (flags.enabled),
        .txreg_empty_o  (flags.txreg_empty),
        .tx_all_empty_o (flags.tx_all_empty)
    );

    spi_stat_rxflags u_rx (
        .clk          (clk),
        .rst          (rst),
        .rx_load_i    (rx_load_i),
        .rdr_rd_i     (rdr_rd_i),
        .sr_rd_i      (sr_rd_i),
        .modf_i       (modf_i),
        .ss_rise_i    (ss_rise_pulse),
        .rx_full_o    (flags.rx_full),
        .overrun_o    (flags.overrun),
        .mode_fault_o (flags.mode_fault),
        .ss_rise_o    (flags.ss_rise)
    );

    assign status_o = pack_status(flags);

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (status_o == '0));
endmodule

// File: tb/spi_stat_unit_bench.sv
module spi_stat_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_cmd, dis_cmd, tx_wr, tx_load, shift_idle, dly_on, dly_done;
    logic rx_load, rdr_rd, sr_rd, modf, ss_pin;
    logic [31:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_stat_unit u_spi_stat_unit (
        .clk(clk), .rst(rst), .en_cmd_i(en_cmd), .dis_cmd_i(dis_cmd),
        .tx_wr_i(tx_wr), .tx_load_i(tx_load), .shift_idle_i(shift_idle),
        .dly_on_i(dly_on), .dly_done_i(dly_done), .rx_load_i(rx_load),
        .rdr_rd_i(rdr_rd), .sr_rd_i(sr_rd), .modf_i(modf),
        .ss_pin_i(ss_pin), .status_o(status)
    );

    // behavioural reference model
    bit m_en, m_tdre, m_txe, m_nssr, m_ovr, m_modf, m_rdrf;
    bit pin_hist[$];

    always @(posedge clk) begin
        bit was_rise, old_tdre, old_rdrf;
        if (rst) begin
            {m_en, m_tdre, m_txe, m_nssr, m_ovr, m_modf, m_rdrf} = '0;
            pin_hist = {1'b1, 1'b1, 1'b1};
        end else begin
            old_tdre = m_tdre;
            old_rdrf = m_rdrf;
            was_rise = pin_hist[1] && !pin_hist[2];
            pin_hist.push_front(ss_pin);
            void'(pin_hist.pop_back());
            // R3 tdre: uses the enable state before this edge
            if (dis_cmd || (!m_en && !en_cmd)) m_tdre = 0;
            else if (en_cmd || tx_load) m_tdre = 1;
            else if (tx_wr) m_tdre = 0;
            if (dis_cmd) m_en = 0; else if (en_cmd) m_en = 1;
            if (tx_wr) m_txe = 0;
            else if (old_tdre && shift_idle && (!dly_on || dly_done)) m_txe = 1;
            if (rx_load && old_rdrf && !rdr_rd) m_ovr = 1; else if (sr_rd) m_ovr = 0;
            if (rx_load) m_rdrf = 1; else if (rdr_rd) m_rdrf = 0;
            if (modf) m_modf = 1; else if (sr_rd) m_modf = 0;
            if (was_rise) m_nssr = 1; else if (sr_rd) m_nssr = 0;
        end
    end

    task automatic chk_bit(string req, int pos, bit exp);
        checks++;
        if (status[pos] !== exp) begin
            fails++;
            $display("FAIL %s bit%0d actual=%0b expected=%0b t=%0t", req, pos, status[pos], exp, $time);
        end
    endtask

    task automatic chk_word(string req, logic [31:0] exp);
        checks++;
        if (status !== exp) begin
            fails++;
            $display("FAIL %s status actual=%h expected=%h t=%0t", req, status, exp, $time);
        end
    endtask

    // compare against the model on every cycle
    always @(negedge clk) begin
        if (!rst) begin
            chk_bit("R2", 16, m_en);
            chk_bit("R3", 1, m_tdre);
            chk_bit("R4", 9, m_txe);
            chk_bit("R5", 8, m_nssr);
            chk_bit("R6", 3, m_ovr);
            chk_bit("R7", 2, m_modf);
            chk_bit("R8", 0, m_rdrf);
            checks++;
            if ((status & ~32'h0001_030F) !== 32'h0) begin
                fails++;
                $display("FAIL R1 reserved actual=%h expected=00000000", status & ~32'h0001_030F);
            end
        end
    end

    task automatic idle_all();
        {en_cmd, dis_cmd, tx_wr, tx_load, dly_done, rx_load, rdr_rd, sr_rd, modf} = '0;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        idle_all();
    endtask

    initial begin
        idle_all();
        shift_idle = 1; dly_on = 0; ss_pin = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk_word("R1", 32'h0);                        // reset state
        en_cmd = 1; tick(1);
        chk_word("R2 R3", 32'h0001_0002);             // enabled + tdre
        tick(1);
        chk_word("R4", 32'h0001_0202);                // all empty follows
        tx_wr = 1; shift_idle = 0; tick(1);
        chk_word("R3 R4", 32'h0001_0000);
        en_cmd = 1; tick(1);                          // re-enable while enabled
        chk_bit("R3 re-enable", 1, 1);
        tx_wr = 1; tick(1);
        tx_load = 1; tick(1);
        chk_bit("R3 handoff", 1, 1);
        dly_on = 1; shift_idle = 1; tick(3);
        chk_bit("R4 waits delay", 9, 0);
        dly_done = 1; tick(1);
        chk_bit("R4 delay done", 9, 1);
        dly_on = 0;
        rx_load = 1; tick(1);
        rx_load = 1; tick(1);                         // double load, no read
        chk_bit("R6 double load", 3, 1);
        sr_rd = 1; tick(1);
        chk_bit("R6 cleared", 3, 0);
        rdr_rd = 1; tick(1);
        chk_bit("R8 read", 0, 0);
        rx_load = 1; tick(1);
        rx_load = 1; rdr_rd = 1; tick(1);             // read with load: no overrun
        chk_bit("R6 read same cycle", 3, 0);
        modf = 1; sr_rd = 1; tick(1);
        chk_bit("R9 modf set wins", 2, 1);
        ss_pin = 0; tick(4);
        ss_pin = 1; tick(2);
        chk_bit("R5 not yet", 8, 0);
        tick(1);
        chk_bit("R5 edge", 8, 1);
        dis_cmd = 1; en_cmd = 1; tick(1);
        chk_bit("R2 disable wins", 16, 0);
        chk_bit("R3 disabled", 1, 0);
        // random phase checked by the model
        for (int i = 0; i < 4000; i++) begin
            en_cmd   = ($urandom_range(0, 15) == 0);
            dis_cmd  = ($urandom_range(0, 31) == 0);
            tx_wr    = ($urandom_range(0, 5) == 0);
            tx_load  = ($urandom_range(0, 5) == 0);
            dly_done = ($urandom_range(0, 3) == 0);
            rx_load  = ($urandom_range(0, 3) == 0);
            rdr_rd   = ($urandom_range(0, 4) == 0);
            sr_rd    = ($urandom_range(0, 6) == 0);
            modf     = ($urandom_range(0, 20) == 0);
            if ($urandom_range(0, 7) == 0) shift_idle = ~shift_idle;
            if ($urandom_range(0, 30) == 0) dly_on = ~dly_on;
            if ($urandom_range(0, 5) == 0) ss_pin = ~ss_pin;
            @(negedge clk);
        end
        idle_all();
        rst = 1; @(negedge clk); rst = 0; @(negedge clk);
        chk_word("R1 second reset", 32'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule